// File: doc/BRIEF.md
# Hold-Based Arbiter Protocol Watchdog

This block sits beside an arbiter that serves several requesters. It only observes: it drives nothing back into the arbiter. A requester raises its request line and keeps it high until the arbiter answers with a grant pulse one cycle wide. The requester then holds the shared resource until it returns an acknowledge pulse one cycle wide. The watchdog follows every requester through three states: idle, waiting and owning. From these states and the live request, grant and acknowledge vectors it finds four classes of fault. These are overlapping ownership, grants nobody asked for, requesters left waiting too long, and handshake misuse.

Each fault class has its own sticky flag. A flag stays set until the synchronous clear input is asserted. Any cycle that contains a fault also produces a registered one-cycle pulse with a numeric fault code. Integration logic can count these pulses, or use them to stop a run. The number of requesters and the wait bound are parameters.

Top module: `arb_watch`

## Requirements
- R1: While reset is asserted and after it is released, `err_pulse`, `err_code` and `err_flags` are all zero until a fault is seen.
- R2: A cycle with more than one bit of `gnt` high is a mutex fault (code 1, flag bit 0).
- R3: A grant to one requester in a cycle where a different requester is owning and not acknowledging in that same cycle is a mutex fault (code 1).
- R4: A grant bit that is high while the same requester's `req` bit is low is a waste fault (code 2, flag bit 1).
- R5: Take the cycle in which an idle requester's `req` is first seen high as cycle 0. If that requester still holds `req` without a grant in cycle `WAIT_LIMIT`, a starvation fault (code 3, flag bit 2) is raised once. A grant in cycle `WAIT_LIMIT` or earlier is legal.
- R6: A waiting requester that drops `req` before any grant arrives causes a protocol fault (code 4, flag bit 3).
- R7: An `ack` bit from a requester that is not owning causes a protocol fault (code 4).
- R8: A `gnt` or `ack` bit that stays high for two consecutive cycles causes a protocol fault (code 4). A grant to a requester that already owns is also a protocol fault.
- R9: When several fault classes occur in one cycle, every matching flag bit is set and `err_code` reports the lowest code.
- R10: Flags stay set until a cycle with `clr` high, after which they read zero. A fault in the clearing cycle itself still sets its flag.
- R11: `err_pulse` and `err_code` appear in the cycle after the faulting cycle and last one cycle. `err_code` is 0 whenever `err_pulse` is low.
- R12: An acknowledge from the owner in the same cycle as a grant to the next requester is a legal handover and causes no fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the sticky flags |
| req | input | NUM_REQ | Request lines, one per requester |
| gnt | input | NUM_REQ | Grant pulses from the arbiter |
| ack | input | NUM_REQ | Release pulses from the requesters |
| err_flags | output | 4 | Sticky flags: bit0 mutex, bit1 waste, bit2 starvation, bit3 protocol |
| err_pulse | output | 1 | One-cycle fault indication |
| err_code | output | 3 | Code of the lowest fault class in the reported cycle |

## Verification
The embedded assertions check invariants on every cycle. A flag only falls after a clear. Every pulse carries a nonzero code whose flag is set. Any fault produces a pulse on the next cycle. A requester reaches the owning state only through a grant. An owner's acknowledge returns it to idle. The wait counter stays bounded, and the starvation report fires only once. Other behaviour needs the bench's directed scenarios. These include the exact cycle in which starvation is declared against a grant that arrives just in time, the legal same-cycle handover, the lowest-code choice when fault classes collide, and a fault that coincides with a clear.

// File: rtl/arb_watch_pkg.sv
package arb_watch_pkg;

  typedef enum logic [1:0] {
    LS_IDLE = 2'd0,
    LS_WAIT = 2'd1,
    LS_OWN  = 2'd2
  } lane_st_t;

  localparam int unsigned FAULT_KINDS = 4;
  localparam int unsigned CODE_W      = 3;

  localparam int unsigned F_MUTEX  = 0;
  localparam int unsigned F_WASTE  = 1;
  localparam int unsigned F_STARVE = 2;
  localparam int unsigned F_PROTO  = 3;

endpackage

// File: rtl/arb_watch_lane.sv
module arb_watch_lane
  import arb_watch_pkg::*;
#(
  parameter int unsigned WAIT_LIMIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic gnt,
  input  logic ack,
  output logic owning,
  output logic waste_o,
  output logic starve_o,
  output logic proto_o
);

  localparam int unsigned CNT_W = $clog2(WAIT_LIMIT + 2);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(WAIT_LIMIT);

  lane_st_t         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             gnt_q, ack_q;

  assign owning = (st_q == LS_OWN);

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    waste_o  = gnt && !req;
    starve_o = 1'b0;
    proto_o  = (gnt && gnt_q) || (ack && ack_q);
    case (st_q)
      LS_IDLE: begin
        if (ack) proto_o = 1'b1;
        if (req && gnt) begin
          st_d = LS_OWN;
        end else if (req) begin
          st_d  = LS_WAIT;
          cnt_d = CNT_W'(1);
        end
      end
      LS_WAIT: begin
        if (ack) proto_o = 1'b1;
        if (!req) begin
          st_d = LS_IDLE;
          if (!gnt) proto_o = 1'b1;
        end else if (gnt) begin
          st_d = LS_OWN;
        end else begin
          if (cnt_q == LIM) starve_o = 1'b1;
          if (cnt_q <= LIM) cnt_d = cnt_q + CNT_W'(1);
        end
      end
      LS_OWN: begin
        if (gnt) proto_o = 1'b1;
        if (ack) st_d = LS_IDLE;
      end
      default: st_d = LS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LS_IDLE;
      cnt_q <= '0;
      gnt_q <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      gnt_q <= gnt;
      ack_q <= ack;
    end
  end

  AST_OWN_VIA_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LS_OWN) |-> ($past(gnt) || $past(st_q == LS_OWN))) else $error("own without grant"); // R12
  AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LS_OWN && ack) |=> (st_q == LS_IDLE)) else $error("ack kept ownership"); // R7
  AST_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LS_WAIT) |-> (cnt_q <= LIM + CNT_W'(1))) else $error("wait counter overrun"); // R5
  AST_STARVE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    starve_o |=> !starve_o) else $error("starvation repeated"); // R5

endmodule

// File: rtl/arb_watch_report.sv
module arb_watch_report
  import arb_watch_pkg::*;
#(
  parameter int unsigned KINDS = FAULT_KINDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [KINDS-1:0]  evt,
  output logic [KINDS-1:0]  flags,
  output logic              pulse,
  output logic [CODE_W-1:0] code
);

  logic [KINDS-1:0]  flags_q, flags_d;
  logic              pulse_q;
  logic [CODE_W-1:0] code_q, code_d;
  logic              flag_en;

  always_comb begin
    code_d = '0;
    for (int k = KINDS - 1; k >= 0; k--) begin
      if (evt[k]) code_d = CODE_W'(k + 1);
    end
  end

  assign flag_en = clr || (|evt);
  assign flags_d = (clr ? '0 : flags_q) | evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (flag_en) begin
      flags_q <= flags_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      code_q  <= '0;
    end else begin
      pulse_q <= |evt;
      code_q  <= code_d;
    end
  end

  assign flags = flags_q;
  assign pulse = pulse_q;
  assign code  = code_q;

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(flags_q) & ~flags_q)) |-> $past(clr)) else $error("flag fell without clear"); // R10
  AST_QUIET_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_q |-> (code_q == '0)) else $error("code without pulse"); // R11
  AST_EVT_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> pulse_q) else $error("fault not reported"); // R11
  AST_CODE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (code_q != '0 && flags_q[code_q - CODE_W'(1)])) else $error("code flag missing"); // R9

endmodule

// File: rtl/arb_watch.sv
module arb_watch
  import arb_watch_pkg::*;
#(
  parameter int unsigned NUM_REQ    = 4,
  parameter int unsigned WAIT_LIMIT = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic [NUM_REQ-1:0]     req,
  input  logic [NUM_REQ-1:0]     gnt,
  input  logic [NUM_REQ-1:0]     ack,
  output logic [FAULT_KINDS-1:0] err_flags,
  output logic                   err_pulse,
  output logic [CODE_W-1:0]      err_code
);

  logic [NUM_REQ-1:0]     own, busy, clash, waste, starve, proto;
  logic                   multi_gnt;
  logic [FAULT_KINDS-1:0] evt;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_REQ; gi++) begin : g_lane
      arb_watch_lane #(.WAIT_LIMIT(WAIT_LIMIT)) u_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req[gi]),
        .gnt      (gnt[gi]),
        .ack      (ack[gi]),
        .owning   (own[gi]),
        .waste_o  (waste[gi]),
        .starve_o (starve[gi]),
        .proto_o  (proto[gi])
      );
      assign busy[gi]  = own[gi] && !ack[gi];
      assign clash[gi] = gnt[gi] && |(busy & ~(NUM_REQ'(1) << gi));
    end
  endgenerate

  assign multi_gnt = |(gnt & (gnt - NUM_REQ'(1)));

  always_comb begin
    evt           = '0;
    evt[F_MUTEX]  = multi_gnt || (|clash);
    evt[F_WASTE]  = |waste;
    evt[F_STARVE] = |starve;
    evt[F_PROTO]  = |proto;
  end

  arb_watch_report #(.KINDS(FAULT_KINDS)) u_report (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .evt   (evt),
    .flags (err_flags),
    .pulse (err_pulse),
    .code  (err_code)
  );

  AST_MULTI_GNT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(gnt) > 1) |=> (err_flags[F_MUTEX] && err_code == CODE_W'(1))) else $error("double grant missed"); // R2
  AST_WASTE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (|(gnt & ~req)) |=> err_flags[F_WASTE]) else $error("waste missed"); // R4

endmodule

// File: tb/arb_watch_test.sv
`timescale 1ns/1ps
module arb_watch_test;

  localparam int unsigned N   = 4;
  localparam int unsigned LIM = 10;

  typedef struct {
    logic       pulse;
    logic [2:0] code;
    logic [3:0] flags;
    string      tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         clr;
  logic [N-1:0] req, gnt, ack;
  logic [3:0]   err_flags;
  logic         err_pulse;
  logic [2:0]   err_code;

  exp_t       exp_q[$];
  logic [3:0] model_flags;
  int         checks = 0;
  int         fails  = 0;
  bit         done   = 0;

  arb_watch #(.NUM_REQ(N), .WAIT_LIMIT(LIM)) uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .req(req), .gnt(gnt), .ack(ack),
    .err_flags(err_flags), .err_pulse(err_pulse), .err_code(err_code)
  );

  always #2 clk = ~clk;

  task automatic step(input logic [N-1:0] r, input logic [N-1:0] g,
                      input logic [N-1:0] a, input logic c,
                      input logic [3:0] setm, input string tag);
    exp_t e;
    @(negedge clk);
    req = r; gnt = g; ack = a; clr = c;
    model_flags = (c ? 4'b0 : model_flags) | setm;
    e.pulse = |setm;
    e.code  = 3'd0;
    for (int k = 3; k >= 0; k--) if (setm[k]) e.code = 3'(k + 1);
    e.flags = model_flags;
    e.tag   = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle_n(input int n, input string tag);
    for (int i = 0; i < n; i++) step('0, '0, '0, 1'b0, 4'b0, tag);
  endtask

  always begin
    exp_t e;
    @(posedge clk);
    #1;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      checks++;
      if (err_pulse !== e.pulse || err_code !== e.code || err_flags !== e.flags) begin
        fails++;
        $display("FAIL %s: pulse/code/flags got %b/%0d/%b expected %b/%0d/%b",
                 e.tag, err_pulse, err_code, err_flags, e.pulse, e.code, e.flags);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; req = '0; gnt = '0; ack = '0;
    model_flags = 4'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (err_pulse !== 1'b0 || err_code !== 3'd0 || err_flags !== 4'b0) begin
      fails++;
      $display("FAIL R1 in reset: got %b/%0d/%b expected 0/0/0000", err_pulse, err_code, err_flags);
    end
    rst_n = 1'b1;
    idle_n(2, "R1 after reset");

    // Normal handshake, including a grant in the first request cycle
    step(4'h1, 4'h0, 4'h0, 0, 4'b0, "R11 normal wait");
    step(4'h1, 4'h1, 4'h0, 0, 4'b0, "R11 normal grant");
    step(4'h1, 4'h0, 4'h0, 0, 4'b0, "R11 normal hold");
    step(4'h0, 4'h0, 4'h1, 0, 4'b0, "R11 normal ack");
    step(4'h2, 4'h2, 4'h0, 0, 4'b0, "R11 same-cycle grant");
    step(4'h0, 4'h0, 4'h2, 0, 4'b0, "R11 ack");

    // R12 handover
    step(4'h3, 4'h1, 4'h0, 0, 4'b0, "R12 first owner");
    step(4'h2, 4'h0, 4'h0, 0, 4'b0, "R12 second waits");
    step(4'h2, 4'h2, 4'h1, 0, 4'b0, "R12 handover");
    step(4'h0, 4'h0, 4'h2, 0, 4'b0, "R12 release");

    // R2 two grants in one cycle
    step(4'h3, 4'h3, 4'h0, 0, 4'b0001, "R2 double grant");
    step(4'h0, 4'h0, 4'h3, 0, 4'b0, "R2 both ack");
    step(4'h0, 4'h0, 4'h0, 1, 4'b0, "R10 clear");

    // R3 grant while another owns
    step(4'h1, 4'h1, 4'h0, 0, 4'b0, "R3 owner");
    step(4'h2, 4'h2, 4'h0, 0, 4'b0001, "R3 overlap grant");
    step(4'h0, 4'h0, 4'h3, 0, 4'b0, "R3 release");
    step(4'h0, 4'h0, 4'h0, 1, 4'b0, "R10 clear");

    // R4 waste
    step(4'h0, 4'h4, 4'h0, 0, 4'b0010, "R4 grant without request");
    step(4'h0, 4'h0, 4'h0, 0, 4'b0, "R10 flag holds");
    step(4'h0, 4'h0, 4'h0, 1, 4'b0, "R10 clear");

    // R6 request withdrawn
    step(4'h8, 4'h0, 4'h0, 0, 4'b0, "R6 wait");
    step(4'h0, 4'h0, 4'h0, 0, 4'b1000, "R6 request dropped");
    step(4'h0, 4'h0, 4'h0, 1, 4'b0, "R10 clear");

    // R7 ack from non-owner
    step(4'h0, 4'h0, 4'h2, 0, 4'b1000, "R7 stray ack");
    step(4'h0, 4'h0, 4'h0, 1, 4'b0, "R10 clear");

    // R8 stretched grant and ack
    step(4'h1, 4'h1, 4'h0, 0, 4'b0, "R8 grant");
    step(4'h1, 4'h1, 4'h0, 0, 4'b1000, "R8 grant two cycles");
    step(4'h0, 4'h0, 4'h1, 0, 4'b0, "R8 ack");
    step(4'h0, 4'h0, 4'h1, 0, 4'b1000, "R8 ack two cycles");
    step(4'h0, 4'h0, 4'h0, 1, 4'b0, "R10 clear");

    // R5 starvation: no grant by cycle LIM
    step(4'h4, 4'h0, 4'h0, 0, 4'b0, "R5 request raised");
    for (int k = 1; k < LIM; k++) step(4'h4, 4'h0, 4'h0, 0, 4'b0, "R5 within bound");
    step(4'h4, 4'h0, 4'h0, 0, 4'b0100, "R5 bound exceeded");
    step(4'h4, 4'h0, 4'h0, 0, 4'b0, "R5 reported once");
    step(4'h4, 4'h4, 4'h0, 0, 4'b0, "R5 late grant");
    step(4'h0, 4'h0, 4'h4, 0, 4'b0, "R5 release");
    step(4'h0, 4'h0, 4'h0, 1, 4'b0, "R10 clear");

    // R5 grant exactly at the bound is legal
    step(4'h4, 4'h0, 4'h0, 0, 4'b0, "R5 edge raise");
    for (int k = 1; k < LIM; k++) step(4'h4, 4'h0, 4'h0, 0, 4'b0, "R5 edge wait");
    step(4'h4, 4'h4, 4'h0, 0, 4'b0, "R5 grant at bound");
    step(4'h0, 4'h0, 4'h4, 0, 4'b0, "R5 edge release");

    // R9 several classes at once
    step(4'h0, 4'h3, 4'h4, 0, 4'b1011, "R9 lowest code wins");
    step(4'h0, 4'h0, 4'h0, 0, 4'b0, "R9 quiet");

    // R10 fault during clear
    step(4'h0, 4'h0, 4'h2, 1, 4'b1000, "R10 fault with clear");
    step(4'h0, 4'h0, 4'h0, 0, 4'b0, "R10 kept after clear");
    step(4'h0, 4'h0, 4'h0, 1, 4'b0, "R10 final clear");
    idle_n(3, "R11 idle tail");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule